// File: doc/BRIEF.md
# Landing Gear Retraction Controller

This block sequences the raising and lowering of an aircraft's landing gear from a single pilot lever. It is a Moore state machine. Its outputs are decoded from the state register alone. It drives the hydraulic pump, the direction valve, the reset line of a countdown timer and two indicator lamps: one lit while the gear travels and one lit while the gear is down and locked.

Retraction is interlocked. While the ground sensor reports contact, the gear is never driven upward. After lift-off, the machine waits in a holding state until an internal down-counter has run for `HOLD_CYCLES` clock cycles without interruption. Only then, and only if the lever asks for gear up, does raising begin. A touch-down during that wait sends the machine back to the armed state and reloads the counter. Moving the lever while the gear is travelling reverses the direction of travel at once, except that a reversal into raising is refused while the aircraft is on the ground.

The reset input is asynchronous and active low. The block releases it internally through a two-stage synchronizer.

Top module: `gear_ctl`

## Requirements
- R1: While `rst_n` is low, the block is in the armed state without waiting for a clock edge. The outputs are then valve_lower=0, pump_on=0, timer_hold=1, led_motion=0 and led_down=1.
- R2: In the armed state, a clock edge with on_ground=0 moves the machine to the airborne-wait state. In that state timer_hold=0 and all other outputs are 0.
- R3: In the airborne-wait state, a clock edge with on_ground=1 returns the machine to the armed state. The counter is reloaded, so a later wait again takes the full `HOLD_CYCLES`.
- R4: Raising starts on the edge after the counter has expired with lever_down=0. With lever_down=0 held from entry, that is exactly `HOLD_CYCLES`+1 edges after the edge that entered the airborne-wait state. While lever_down=1, the machine stays in the airborne-wait state.
- R5: In the raising state, an edge with stowed_sns=1 and lever_down=0 moves the machine to the gear-up state.
- R6: lever_down=1 sends the raising or gear-up state to lowering on the next edge. lever_down=0 with on_ground=0 sends lowering back to raising.
- R7: In the lowering state, an edge with deployed_sns=1 and lever_down=1 moves the machine to the gear-down state. The gear-down state moves to the armed state on an edge with on_ground=1.
- R8: on_ground=1 sends the raising or gear-up state to lowering. The lowering state never turns to raising while on_ground=1. The machine is never in the raising state on the edge after on_ground=1 was sampled.
- R9: Output encoding, written as {valve_lower,pump_on,timer_hold,led_motion,led_down}: armed 00101, airborne-wait 00000, raising 01110, gear-up 00100, lowering 11110, gear-down 00101.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lever_down | input | 1 | Pilot lever, 1 asks for gear down, 0 for gear up |
| on_ground | input | 1 | 1 while the aircraft touches the ground |
| stowed_sns | input | 1 | 1 when the gear is fully retracted |
| deployed_sns | input | 1 | 1 when the gear is fully extended |
| valve_lower | output | 1 | Direction valve, 1 lowers, 0 raises |
| pump_on | output | 1 | 1 runs the hydraulic pump |
| timer_hold | output | 1 | 1 holds the countdown timer in reset, 0 lets it count |
| led_motion | output | 1 | Lit while the gear is travelling |
| led_down | output | 1 | Lit while the gear is down |

## Verification
Every output is a decode of the state register. A change on a sampled input therefore shows at the outputs right after the next rising edge, one edge of latency. The take-off wait adds a further `HOLD_CYCLES` edges, and reset acts with no edge at all. The bench drives inputs and samples outputs 2 ns after a rising edge. Each step advances an exact number of edges, so every comparison lands on the cycle in which the result is due. For the counter window, the bench checks both the last cycle that must still be waiting and the first cycle that must be raising.

// File: rtl/gear_pkg.sv
package gear_pkg;
  typedef enum logic [2:0] {
    ST_ARMED = 3'd0,  // on the ground, gear down
    ST_CLIMB = 3'd1,  // airborne, counting continuous flight time
    ST_RAISE = 3'd2,  // pump on, valve set to retract
    ST_UP    = 3'd3,  // gear stowed
    ST_LOWER = 3'd4,  // pump on, valve set to extend
    ST_DOWN  = 3'd5   // gear extended in flight
  } gear_st_e;
endpackage

// File: rtl/gear_rst_sync.sv
module gear_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gear_timer.sv
module gear_timer #(
  parameter int HOLD_CYCLES = 250_000_000,
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic time_up
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = hold || (cnt_q != '0);
    if (hold)               cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign time_up = !hold && (cnt_q == '0);

  // R4: once expired, the flag stays up until the timer is held again
  assert_expiry_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    time_up |=> (hold || time_up));
endmodule

// File: rtl/gear_fsm.sv
module gear_fsm
  import gear_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lever_down,
  input  logic     on_ground,
  input  logic     stowed_sns,
  input  logic     deployed_sns,
  input  logic     time_up,
  output gear_st_e state
);
  gear_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED: if (!on_ground) state_d = ST_CLIMB;
      ST_CLIMB: begin
        if (on_ground)                   state_d = ST_ARMED;
        else if (time_up && !lever_down) state_d = ST_RAISE;
      end
      ST_RAISE: begin
        if (lever_down || on_ground) state_d = ST_LOWER;
        else if (stowed_sns)         state_d = ST_UP;
      end
      ST_UP:    if (lever_down || on_ground) state_d = ST_LOWER;
      ST_LOWER: begin
        if (!lever_down && !on_ground) state_d = ST_RAISE;
        else if (deployed_sns && lever_down) state_d = ST_DOWN;
      end
      ST_DOWN:  if (on_ground) state_d = ST_ARMED;
      default:  state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARMED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R8: ground contact is never followed by retraction
  assert_no_raise_on_ground_R8: assert property (@(posedge clk) disable iff (!rst_n)
    on_ground |=> (state_q != ST_RAISE));

  // R4: leaving the airborne wait for raising needs an expired timer and lever up
  assert_raise_needs_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RAISE && $past(state_q) == ST_CLIMB) |-> ($past(time_up) && !$past(lever_down)));
endmodule

// File: rtl/gear_outdec.sv
module gear_outdec
  import gear_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  gear_st_e state,
  output logic     valve_lower,
  output logic     pump_on,
  output logic     timer_hold,
  output logic     led_motion,
  output logic     led_down
);
  always_comb begin
    valve_lower = 1'b0;
    pump_on     = 1'b0;
    timer_hold  = 1'b1;
    led_motion  = 1'b0;
    led_down    = 1'b0;
    unique case (state)
      ST_ARMED: led_down = 1'b1;
      ST_CLIMB: timer_hold = 1'b0;
      ST_RAISE: begin pump_on = 1'b1; led_motion = 1'b1; end
      ST_UP:    ;
      ST_LOWER: begin pump_on = 1'b1; led_motion = 1'b1; valve_lower = 1'b1; end
      ST_DOWN:  led_down = 1'b1;
      default:  ;
    endcase
  end

  // R9: the down lamp and the pump are never on together
  assert_lamp_vs_pump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    led_down |-> !pump_on);

  // R9: the timer only runs while the pump is idle
  assert_timer_idle_pump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_hold |-> !pump_on);
endmodule

// File: rtl/gear_ctl.sv
module gear_ctl
  import gear_pkg::*;
#(
  parameter int HOLD_CYCLES = 250_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lever_down,
  input  logic on_ground,
  input  logic stowed_sns,
  input  logic deployed_sns,
  output logic valve_lower,
  output logic pump_on,
  output logic timer_hold,
  output logic led_motion,
  output logic led_down
);
  logic     rst_i_n;
  logic     time_up;
  gear_st_e state;

  gear_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  gear_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .hold    (timer_hold),
    .time_up (time_up)
  );

  gear_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .lever_down   (lever_down),
    .on_ground    (on_ground),
    .stowed_sns   (stowed_sns),
    .deployed_sns (deployed_sns),
    .time_up      (time_up),
    .state        (state)
  );

  gear_outdec u_dec (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .state       (state),
    .valve_lower (valve_lower),
    .pump_on     (pump_on),
    .timer_hold  (timer_hold),
    .led_motion  (led_motion),
    .led_down    (led_down)
  );

  // R2: the timer is released only after lift-off has been sampled
  assert_release_after_liftoff_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(timer_hold) |-> !$past(on_ground));
endmodule

// File: tb/gear_ctl_tb.sv
module gear_ctl_tb_top;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic lever_down, on_ground, stowed_sns, deployed_sns;
  logic valve_lower, pump_on, timer_hold, led_motion, led_down;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gear_ctl #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .lever_down(lever_down), .on_ground(on_ground),
    .stowed_sns(stowed_sns), .deployed_sns(deployed_sns),
    .valve_lower(valve_lower), .pump_on(pump_on), .timer_hold(timer_hold),
    .led_motion(led_motion), .led_down(led_down)
  );

  // {valve_lower,pump_on,timer_hold,led_motion,led_down}
  localparam logic [4:0] O_ARMED = 5'b00101;
  localparam logic [4:0] O_CLIMB = 5'b00000;
  localparam logic [4:0] O_RAISE = 5'b01110;
  localparam logic [4:0] O_UP    = 5'b00100;
  localparam logic [4:0] O_LOWER = 5'b11110;
  localparam logic [4:0] O_DOWN  = 5'b00101;

  // {lever,ground,stowed,deployed}, edges to advance, expected outputs
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {4'b1101, 8'd2,  O_ARMED},  // R1 armed holds on ground
    {4'b1001, 8'd1,  O_CLIMB},  // R2 lift-off
    {4'b1001, 8'd20, O_CLIMB},  // R4 lever down blocks raising
    {4'b0000, 8'd1,  O_RAISE},  // R4 expired timer, lever up
    {4'b0000, 8'd3,  O_RAISE},  // R5 waits for stowed sensor
    {4'b0010, 8'd1,  O_UP},     // R5 stowed
    {4'b1010, 8'd1,  O_LOWER},  // R6 lever down from gear-up
    {4'b0000, 8'd1,  O_RAISE},  // R6 reversal to raising in flight
    {4'b1000, 8'd1,  O_LOWER},  // R6 reversal to lowering
    {4'b1001, 8'd1,  O_DOWN},   // R7 deployed
    {4'b1001, 8'd3,  O_DOWN},   // R7 stays down in flight
    {4'b1101, 8'd1,  O_ARMED}   // R7 touch-down re-arms
  };

  task automatic check(input string tag, input logic [4:0] exp);
    logic [4:0] got;
    got = {valve_lower, pump_on, timer_hold, led_motion, led_down};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {lever_down, on_ground, stowed_sns, deployed_sns} = v;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog got=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive(4'b1101);
    #1;
    check("R1 reset state, no edge yet", O_ARMED);
    step(3);
    check("R1 reset state held", O_ARMED);
    rst_n = 1'b1;
    step(3);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:13]);
      step(int'(VEC[i][12:5]));
      check($sformatf("vector %0d (R1-R9 table)", i), VEC[i][4:0]);
    end

    // R4 exact window: armed on ground, lever up
    drive(4'b0101);
    step(1);
    check("R4 armed before lift-off", O_ARMED);
    drive(4'b0001);
    step(1);
    check("R2 entered airborne wait", O_CLIMB);
    step(HOLD);
    check("R4 last waiting edge", O_CLIMB);
    step(1);
    check("R4 raising at HOLD+1", O_RAISE);

    // R8 landing while raising
    drive(4'b0100);
    step(1);
    check("R8 ground contact forces lowering", O_LOWER);
    step(2);
    check("R8 no reversal to raising on ground", O_LOWER);
    drive(4'b1101);
    step(1);
    check("R7 deployed on ground", O_DOWN);
    step(1);
    check("R7 ground re-arms", O_ARMED);

    // R3 touch-down during the wait reloads the counter
    drive(4'b0001);
    step(1);
    check("R2 lift-off again", O_CLIMB);
    step(5);
    check("R3 partway through wait", O_CLIMB);
    drive(4'b0101);
    step(1);
    check("R3 bounce returns to armed", O_ARMED);
    drive(4'b0001);
    step(1);
    check("R3 wait restarted", O_CLIMB);
    step(HOLD);
    check("R3 full wait after reload", O_CLIMB);
    step(1);
    check("R3 raising after full wait", O_RAISE);

    // R8 landing with gear stowed
    drive(4'b0010);
    step(1);
    check("R5 stowed", O_UP);
    drive(4'b0110);
    step(1);
    check("R8 gear-up on ground lowers", O_LOWER);

    // R1 asynchronous reset in motion
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid-travel", O_ARMED);
    step(2);
    check("R1 held in reset", O_ARMED);

    finish_run();
  end
endmodule